// File: doc/BRIEF.md
# Interrupt message write status tracker

This block issues the memory writes that deliver interrupts for three error interrupt sources: fault handling, error recovery and critical error. A one-cycle trigger pulse from a source starts one posted write on a shared request/response write port. The write's address and data come from plain per-source configuration inputs. The block reports what each source's write is doing through one 64-bit status word, reached through a small register read/write port.

Each source has two status bits. The first is a read-only flag that shows a triggered write has not yet finished. It does not show that the interrupt itself is active. The second is a sticky flag that records an error response, and software clears it by writing a one to it. The write port carries one write at a time. When several sources are waiting, critical is served first, then error recovery, then fault handling. A source that triggers again while its write is outstanding gets exactly one further write after the current one completes.

Source indices are fault handling = 0, error recovery = 1 and critical = 2. The status field of source i starts at bit 8*i.

Top module: `irq_msg_tracker`

## Requirements
- R1: After reset the status word reads all zero and `wr_req_o` is low.
- R2: A trigger on source i produces one write carrying `msg_addr_i`/`msg_data_i` slice i. `wr_req_o` stays high with stable address and data until the cycle in which `wr_ack_i` is sampled high.
- R3: The in-progress bit of source i (bit 8*i: bits 0, 8 and 16) reads 1 from the clock edge after the trigger until the edge that takes that write's response.
- R4: Register writes have no effect on the in-progress bits.
- R5: An error response (`rsp_valid_i` and `rsp_err_i` both high) sets the error bit of the source that owns the write (bit 8*i+1: bits 1, 9 and 17). The bit stays set until cleared.
- R6: A register write to offset 0xEF8 with a 1 in an error bit position clears that bit. A 0 in that position, or a write to any other offset, leaves the bit unchanged.
- R7: All bits of the status word other than the six status bits read 0. A read of any other offset returns 0. `reg_rdata_o` shows the value from the edge at which `reg_rd_i` was sampled and is 0 in every other cycle.
- R8: A source has at most one write outstanding. Triggers that arrive while its write is queued merge into that write. One or more triggers that arrive while its write is on the port cause exactly one further write after the response.
- R9: At most one write is outstanding on the port. `wr_req_o` is low while a response is awaited. Sources that are waiting at the same time are granted in the order critical, error recovery, fault handling.
- R10: When an error response and a write-1-to-clear hit the same error bit in the same cycle, the bit ends up set.
- R11: With `CFG_EN` = 0, the status word reads 0, register writes are ignored and no write is ever requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 3 | Trigger pulse per source (bit 0 fault, 1 recovery, 2 critical) |
| msg_addr_i | input | 3*ADDR_W | Write address per source, source i at slice i |
| msg_data_i | input | 3*DATA_W | Write data per source, source i at slice i |
| wr_req_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write request accepted |
| rsp_valid_i | input | 1 | Write response valid |
| rsp_err_i | input | 1 | Write response reports an error |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, one cycle after the read strobe |

## Verification
The bench builds two instances with the default 32-bit address and data and a 12-bit register offset. One has `CFG_EN` = 1. The other has `CFG_EN` = 0 and is driven with the same stimulus, so every read and trigger also checks the disabled variant. Three sources make it possible to sweep every trigger combination against every error-response pattern (64 cases). Each case checks the grant order, the in-progress bits and the sticky error bits. Directed sequences add retriggers while a write is queued or in flight, writes to read-only and reserved bits, a wrong offset, and an error response colliding with a clear.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    // number of interrupt sources and spacing of their status fields
    localparam int unsigned NSRC         = 3;
    localparam int unsigned FIELD_STRIDE = 8;
    localparam int unsigned STAT_W       = 64;

    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_ACTIVE = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_RSP  = 2'd2
    } eng_st_e;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_msg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic grant_i,
    input  logic done_i,
    input  logic done_err_i,
    input  logic clr_i,
    output logic busy_o,
    output logic wait_o,
    output logic err_o
);

    typedef struct packed {
        slot_st_e st;
        logic     again;
        logic     err;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  again_n;

    always_comb begin
        slot_d  = slot_q;
        again_n = slot_q.again | trig_i;
        unique case (slot_q.st)
            SLOT_IDLE: begin
                if (trig_i) slot_d.st = SLOT_WAIT;
            end
            SLOT_WAIT: begin
                // repeat triggers merge into the queued write
                if (grant_i) slot_d.st = SLOT_ACTIVE;
            end
            SLOT_ACTIVE: begin
                if (done_i) begin
                    slot_d.st    = again_n ? SLOT_WAIT : SLOT_IDLE;
                    slot_d.again = 1'b0;
                end else begin
                    slot_d.again = again_n;
                end
            end
            default: slot_d.st = SLOT_IDLE;
        endcase
        // clear first, a fresh error response overrides it
        if (clr_i)                slot_d.err = 1'b0;
        if (done_i && done_err_i) slot_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{st: SLOT_IDLE, again: 1'b0, err: 1'b0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy_o = (slot_q.st != SLOT_IDLE);
    assign wait_o = (slot_q.st == SLOT_WAIT);
    assign err_o  = slot_q.err;

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !clr_i |=> err_o);
    p_err_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && done_err_i |=> err_o);
    p_busy_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_i |=> busy_o);
    p_grant_when_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> wait_o);

endmodule

// File: rtl/irq_msg_engine.sv
module irq_msg_engine
    import irq_msg_pkg::*;
#(
    parameter int unsigned N      = 3,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wait_i,
    input  logic [N*ADDR_W-1:0] addr_i,
    input  logic [N*DATA_W-1:0] data_i,
    output logic [N-1:0]        grant_o,
    output logic [N-1:0]        done_o,
    output logic                done_err_o,
    output logic                wr_req_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [DATA_W-1:0]   wr_data_o,
    input  logic                wr_ack_i,
    input  logic                rsp_valid_i,
    input  logic                rsp_err_i
);

    localparam int unsigned OW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        eng_st_e           st;
        logic [OW-1:0]     owner;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic [OW-1:0] sel;
    logic          any_wait;

    // highest index wins: critical (2) above recovery (1) above fault (0)
    always_comb begin
        sel      = '0;
        any_wait = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (wait_i[i]) begin
                sel      = OW'(i);
                any_wait = 1'b1;
            end
        end
    end

    always_comb begin
        eng_d   = eng_q;
        grant_o = '0;
        done_o  = '0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (any_wait) begin
                    grant_o[sel] = 1'b1;
                    eng_d.st     = ENG_REQ;
                    eng_d.owner  = sel;
                    eng_d.addr   = addr_i[sel*ADDR_W +: ADDR_W];
                    eng_d.data   = data_i[sel*DATA_W +: DATA_W];
                end
            end
            ENG_REQ: begin
                if (wr_ack_i) eng_d.st = ENG_RSP;
            end
            ENG_RSP: begin
                if (rsp_valid_i) begin
                    done_o[eng_q.owner] = 1'b1;
                    eng_d.st            = ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, owner: '0, addr: '0, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_req_o   = (eng_q.st == ENG_REQ);
    assign wr_addr_o  = eng_q.addr;
    assign wr_data_o  = eng_q.data;
    assign done_err_o = rsp_err_i;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_no_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (grant_o == '0));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done_o) <= 1);

    for (genvar g = 0; g < int'(N); g++) begin : g_prio
        p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[g] |-> ((wait_i >> (g + 1)) == '0));
    end

endmodule

// File: rtl/irq_stat_regif.sv
module irq_stat_regif
    import irq_msg_pkg::*;
#(
    parameter int unsigned     N           = 3,
    parameter int unsigned     REG_AW      = 12,
    parameter logic [REG_AW-1:0] STAT_OFFSET = 12'hEF8,
    parameter bit              CFG_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    input  logic [N-1:0]      busy_i,
    input  logic [N-1:0]      err_i,
    output logic [N-1:0]      clr_o,
    output logic [STAT_W-1:0] reg_rdata_o
);

    typedef struct packed {
        logic [STAT_W-1:0] rdata;
    } rif_t;

    rif_t              rif_d, rif_q;
    logic              hit;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] wmask;

    assign hit = (reg_addr_i == STAT_OFFSET);

    // assemble status word and clear strobes from the per-source fields
    for (genvar g = 0; g < int'(N); g++) begin : g_field
        if (CFG_EN) begin : g_on
            assign clr_o[g] = reg_wr_i && hit && reg_wdata_i[g*FIELD_STRIDE + 1];
        end else begin : g_off
            assign clr_o[g] = 1'b0;
        end
    end

    always_comb begin
        status = '0;
        wmask  = '0;
        for (int i = 0; i < int'(N); i++) begin
            wmask[i*FIELD_STRIDE + 1] = 1'b1;
            if (CFG_EN) begin
                status[i*FIELD_STRIDE]     = busy_i[i];
                status[i*FIELD_STRIDE + 1] = err_i[i];
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^(reg_wdata_i & ~wmask);

    always_comb begin
        rif_d       = rif_q;
        rif_d.rdata = (reg_rd_i && hit) ? status : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rif_q <= '{rdata: '0};
        end else begin
            rif_q <= rif_d;
        end
    end

    assign reg_rdata_o = rif_q.rdata;

    p_idle_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> (reg_rdata_o == '0));
    p_miss_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i && !hit |=> (reg_rdata_o == '0));
    p_no_clr_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |-> (clr_o == '0));

endmodule

// File: rtl/irq_msg_tracker.sv
module irq_msg_tracker
    import irq_msg_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       REG_AW      = 12,
    parameter logic [REG_AW-1:0] STAT_OFFSET = 12'hEF8,
    parameter bit                CFG_EN      = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             trig_i,
    input  logic [3*ADDR_W-1:0]    msg_addr_i,
    input  logic [3*DATA_W-1:0]    msg_data_i,
    output logic                   wr_req_o,
    output logic [ADDR_W-1:0]      wr_addr_o,
    output logic [DATA_W-1:0]      wr_data_o,
    input  logic                   wr_ack_i,
    input  logic                   rsp_valid_i,
    input  logic                   rsp_err_i,
    input  logic                   reg_wr_i,
    input  logic                   reg_rd_i,
    input  logic [REG_AW-1:0]      reg_addr_i,
    input  logic [63:0]            reg_wdata_i,
    output logic [63:0]            reg_rdata_o
);

    localparam int unsigned N = NSRC;

    logic [N-1:0] trig_eff;
    logic [N-1:0] grant, done, busy, waiting, err, clr;
    logic         done_err;

    assign trig_eff = CFG_EN ? trig_i : '0;

    for (genvar g = 0; g < int'(N); g++) begin : g_slot
        irq_src_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_i     (trig_eff[g]),
            .grant_i    (grant[g]),
            .done_i     (done[g]),
            .done_err_i (done_err),
            .clr_i      (clr[g]),
            .busy_o     (busy[g]),
            .wait_o     (waiting[g]),
            .err_o      (err[g])
        );
    end

    irq_msg_engine #(
        .N      (N),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_i      (waiting),
        .addr_i      (msg_addr_i),
        .data_i      (msg_data_i),
        .grant_o     (grant),
        .done_o      (done),
        .done_err_o  (done_err),
        .wr_req_o    (wr_req_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .wr_ack_i    (wr_ack_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_err_i   (rsp_err_i)
    );

    irq_stat_regif #(
        .N           (N),
        .REG_AW      (REG_AW),
        .STAT_OFFSET (STAT_OFFSET),
        .CFG_EN      (CFG_EN)
    ) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_rd_i    (reg_rd_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .busy_i      (busy),
        .err_i       (err),
        .clr_o       (clr),
        .reg_rdata_o (reg_rdata_o)
    );

    p_one_busy_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy & ~waiting) <= 1);

    if (!CFG_EN) begin : g_off_chk
        p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_req_o && (reg_rdata_o == '0));
    end

endmodule

// File: tb/irq_msg_tracker_bench.sv
module irq_msg_tracker_bench;

    localparam int  AW  = 32;
    localparam int  DW  = 32;
    localparam logic [11:0] OFF = 12'hEF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    trig = '0;
    logic [3*AW-1:0] maddr;
    logic [3*DW-1:0] mdata;
    logic          wr_ack = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [63:0]   reg_wdata = '0;

    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [63:0]   rdata;
    logic          off_req;
    logic [AW-1:0] off_addr;
    logic [DW-1:0] off_data;
    logic [63:0]   off_rdata;

    int nchk = 0;
    int nerr = 0;
    int off_req_seen = 0;
    int off_rd_bad = 0;

    always #10 clk = ~clk;

    irq_msg_tracker u_irq_msg_tracker (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .msg_addr_i(maddr), .msg_data_i(mdata),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
        .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata)
    );

    irq_msg_tracker #(.CFG_EN(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .msg_addr_i(maddr), .msg_data_i(mdata),
        .wr_req_o(off_req), .wr_addr_o(off_addr), .wr_data_o(off_data), .wr_ack_i(wr_ack),
        .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(off_rdata)
    );

    function automatic logic [AW-1:0] addr_of(input int s);
        return 32'h1000_0000 + 32'(s) * 32'h40;
    endfunction
    function automatic logic [DW-1:0] data_of(input int s);
        return 32'hA5A5_0000 + 32'(s);
    endfunction
    // expected status word: in-progress at 8*i, error at 8*i+1
    function automatic logic [63:0] stat(input logic [2:0] b, input logic [2:0] e);
        logic [63:0] v = '0;
        for (int i = 0; i < 3; i++) begin
            v[8*i]     = b[i];
            v[8*i + 1] = e[i];
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && off_req) off_req_seen++;
        if (rst_n && off_rdata != '0) off_rd_bad++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // all tasks are entered and left right after a falling edge
    task automatic rd(input logic [11:0] a, output logic [63:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = '0;
        v = rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic fire(input logic [2:0] m);
        trig = m;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic wait_req();
        int n = 0;
        while (!wr_req && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(wr_req, "R2", 64'(wr_req), 64'd1);
    endtask

    task automatic serve(input int s, input bit e);
        logic [AW-1:0] a0;
        wait_req();
        chk(wr_addr == addr_of(s) && wr_data == data_of(s), "R9",
            {wr_addr, wr_data}, {addr_of(s), data_of(s)});
        a0 = wr_addr;
        @(negedge clk);
        chk(wr_req && wr_addr == a0, "R2", {31'd0, wr_req, wr_addr}, {31'd0, 1'b1, a0});
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        chk(!wr_req, "R9", 64'(wr_req), 64'd0);
        rsp_valid = 1'b1; rsp_err = e;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic idle_check(input string req);
        bit seen = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (wr_req) seen = 1;
        end
        chk(!seen, req, 64'(seen), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        for (int s = 0; s < 3; s++) begin
            maddr[s*AW +: AW] = addr_of(s);
            mdata[s*DW +: DW] = data_of(s);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(OFF, v);
        chk(v == '0, "R1", v, '0);
        chk(!wr_req, "R1", 64'(wr_req), 64'd0);

        // sweep: every trigger combination against every error pattern (R3 R5 R9)
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 8; e++) begin
                wr(OFF, 64'h0002_0202);
                fire(3'(m));
                if (m != 0) begin
                    rd(OFF, v);
                    chk(v == stat(3'(m), 3'b0), "R3", v, stat(3'(m), 3'b0));
                end
                for (int s = 2; s >= 0; s--)
                    if (m[s]) serve(s, e[s]);
                rd(OFF, v);
                chk(v == stat(3'b0, 3'(m & e)), "R5", v, stat(3'b0, 3'(m & e)));
                idle_check("R9");
            end
        end
        wr(OFF, 64'h0002_0202);

        // R4: in-progress bits ignore register writes
        fire(3'b001);
        wait_req();
        wr(OFF, 64'h0001_0101);
        rd(OFF, v);
        chk(v == stat(3'b001, 3'b0), "R4", v, stat(3'b001, 3'b0));
        serve(0, 1'b0);
        wr(OFF, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(OFF, v);
        chk(v == '0, "R4", v, '0);

        // R6: write 0 and wrong offset leave the error bit, write 1 clears
        fire(3'b010);
        serve(1, 1'b1);
        wr(OFF, 64'h0);
        rd(OFF, v);
        chk(v == 64'h200, "R6", v, 64'h200);
        wr(12'hEF0, 64'h200);
        rd(OFF, v);
        chk(v == 64'h200, "R6", v, 64'h200);

        // R7: other offsets read zero, reserved bits read zero
        rd(12'hEF0, v);
        chk(v == '0, "R7", v, '0);
        wr(OFF, 64'hFFFF_FFFF_FFFC_FDFD);
        rd(OFF, v);
        chk(v == 64'h200, "R7", v, 64'h200);
        wr(OFF, 64'h200);
        rd(OFF, v);
        chk(v == '0, "R6", v, '0);

        // R8: repeat triggers while queued merge into one write
        fire(3'b100);
        wait_req();
        fire(3'b001);
        fire(3'b001);
        serve(2, 1'b0);
        serve(0, 1'b0);
        idle_check("R8");

        // R8: repeat triggers while on the port yield exactly one more write
        fire(3'b001);
        wait_req();
        fire(3'b001);
        fire(3'b001);
        serve(0, 1'b0);
        rd(OFF, v);
        chk(v == stat(3'b001, 3'b0), "R8", v, stat(3'b001, 3'b0));
        serve(0, 1'b0);
        idle_check("R8");
        rd(OFF, v);
        chk(v == '0, "R8", v, '0);

        // R10: error response and clear in the same cycle
        fire(3'b010);
        wait_req();
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        rsp_valid = 1'b1; rsp_err = 1'b1;
        reg_wr = 1'b1; reg_addr = OFF; reg_wdata = 64'h200;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rd(OFF, v);
        chk(v == 64'h200, "R10", v, 64'h200);

        // R11: disabled variant never requested a write, never returned data
        chk(off_req_seen == 0, "R11", 64'(off_req_seen), 64'd0);
        chk(off_rd_bad == 0, "R11", 64'(off_rd_bad), 64'd0);

        finish_run();
    end

endmodule